// File: doc/BRIEF.md
# CAN Controller Halt-Mode Sequencer

This block decides when a CAN protocol engine may take part in bus traffic around a halt that software requests. Software holds a halt request level high. The sequencer watches status strobes from the engine and keeps participation enabled until a safe moment. A frame that is being transmitted or received is allowed to finish. Idle and intermission are safe at once. When the halt is taken, the block raises a level status flag and a one-cycle interrupt pulse. It also opens a permit that lets configuration registers be rewritten while the node is off the bus.

If the request arrives while the engine is bus-off, the node is held off the bus. This hold lasts past the engine's normal recovery and ends only when software drops the request. After any release, and after reset, the node must first see a run of consecutive recessive bits, 11 by default. Bits are sampled only on the bit-timing sample strobe. A dominant bit anywhere in the run restarts the count. Only after a complete run is bus participation enabled again.

Top module: `can_halt_seq`

## Requirements
- R1: After synchronous active-high reset, `bus_en`, `halted`, `halt_irq` and `cfg_wr_ok` are all 0. `bus_en` stays 0 until `RUN_LEN` (default 11) consecutive recessive sample strobes have been seen.
- R2: With the request set while `eng_idle` or `eng_intermission` is 1 (and no frame or bus-off is flagged), the halt is taken on the next clock edge: `halted` is 1 and `bus_en` is 0 one cycle later.
- R3: With the request set while `eng_tx` or `eng_rx` is 1, `bus_en` stays 1 and `halted` stays 0 for as long as the frame strobe stays high. The halt is taken on the first edge at which both frame strobes are 0.
- R4: `halt_irq` is a single-cycle pulse in the cycle in which the halt is entered. It is never high for two cycles in a row.
- R5: `halted` stays 1 from halt entry, through the clearing of the request and the rejoin count. It returns to 0 in the same cycle that `bus_en` returns to 1.
- R6: `cfg_wr_ok` is 1 only while the node is halted with the request still set. It drops one cycle after the request is cleared.
- R7: A request made while `eng_bus_off` is 1 keeps `bus_en` at 0, `halted` at 0 and `cfg_wr_ok` at 0. This holds even after bus-off ends and 128 runs of 11 recessive bits pass. Only clearing the request starts the rejoin count.
- R8: After the request is cleared, `bus_en` returns to 1 only after `RUN_LEN` consecutive recessive bits (`rx_bit` = 1). A dominant bit (`rx_bit` = 0) sampled during the run restarts the count from zero.
- R9: `rx_bit` is sampled only in cycles where `bit_tick` is 1. Cycles without the strobe do not advance the rejoin count.
- R10: If the request is cleared while a frame is still finishing, the halt is not taken. `bus_en` stays 1, `halted` stays 0 and no `halt_irq` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt_req | input | 1 | Software halt request level (1 = halt, 0 = normal) |
| eng_tx | input | 1 | Engine is transmitting a frame |
| eng_rx | input | 1 | Engine is receiving a frame |
| eng_idle | input | 1 | Bus is idle |
| eng_intermission | input | 1 | Bus is in intermission |
| eng_bus_off | input | 1 | Engine is bus-off |
| bit_tick | input | 1 | Sample-point strobe, one per nominal bit |
| rx_bit | input | 1 | Sampled receive bit (1 = recessive) |
| bus_en | output | 1 | Engine may take part in bus activity |
| halted | output | 1 | Halted status level |
| halt_irq | output | 1 | One-cycle pulse on halt entry |
| cfg_wr_ok | output | 1 | Configuration writes permitted |

## Verification
Every result is due one clock edge after the stimulus that causes it. Inputs are driven at a falling edge and sampled at the next rising edge, and the state register updates on that edge. The bench therefore reads the outputs at the following falling edge. A halt request under idle or intermission shows up at the first falling edge after it is set. The rejoin is checked bit by bit: each bit is one strobe cycle followed by two quiet cycles. `bus_en` is read after the tenth bit, where it must still be 0, and after the eleventh, where it must be 1. The interrupt pulse is read at the entry edge and again one cycle later to show it is a single cycle.

// File: rtl/can_halt_pkg.sv
package can_halt_pkg;
   typedef enum logic [2:0] {
      ST_REJOIN  = 3'd0,
      ST_ACTIVE  = 3'd1,
      ST_DRAIN   = 3'd2,
      ST_HALTED  = 3'd3,
      ST_BOFF    = 3'd4
   } halt_state_t;
endpackage

// File: rtl/can_halt_runcnt.sv
module can_halt_runcnt #(
   parameter int RUN_LEN = 11
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic tick,
   input  logic bit_in,
   output logic done
);
   localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN + 1) : 1;

   generate
      if (RUN_LEN < 1) begin : g_bad
         $error("RUN_LEN must be at least 1");
      end
      if (RUN_LEN == 1) begin : g_single
         assign done = tick & bit_in;
      end else begin : g_count
         logic [CW-1:0] cnt;
         assign done = tick & bit_in & (cnt == CW'(RUN_LEN - 1));
         always_ff @(posedge clk) begin
            if (rst || clr)       cnt <= '0;
            else if (tick) begin
               if (!bit_in)       cnt <= '0;   // R8: dominant restarts
               else if (done)     cnt <= '0;
               else               cnt <= cnt + 1'b1;
            end
         end
         a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
            cnt < CW'(RUN_LEN));
         a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
            (!tick && !clr) |=> $stable(cnt));
      end
   endgenerate
endmodule

// File: rtl/can_halt_fsm.sv
module can_halt_fsm
   import can_halt_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        halt_req,
   input  logic        eng_tx,
   input  logic        eng_rx,
   input  logic        eng_idle,
   input  logic        eng_intermission,
   input  logic        eng_bus_off,
   input  logic        run_done,
   output halt_state_t state,
   output logic        irq_q,
   output logic        flag_q
);
   halt_state_t nxt;
   logic        in_frame;
   assign in_frame = eng_tx | eng_rx;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_REJOIN: begin
            if (halt_req)      nxt = ST_HALTED;
            else if (run_done) nxt = ST_ACTIVE;
         end
         ST_ACTIVE: begin
            if (halt_req) begin
               if (eng_bus_off)                       nxt = ST_BOFF;
               else if (in_frame)                     nxt = ST_DRAIN;
               else if (eng_idle || eng_intermission) nxt = ST_HALTED;
            end
         end
         ST_DRAIN: begin
            if (!halt_req)      nxt = ST_ACTIVE;
            else if (!in_frame) nxt = ST_HALTED;
         end
         ST_HALTED: if (!halt_req) nxt = ST_REJOIN;
         ST_BOFF:   if (!halt_req) nxt = ST_REJOIN;
         default:   nxt = ST_REJOIN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_REJOIN;
         irq_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         state <= nxt;
         irq_q <= (nxt == ST_HALTED) && (state != ST_HALTED);
         if (nxt == ST_HALTED)      flag_q <= 1'b1;
         else if (nxt == ST_ACTIVE) flag_q <= 1'b0;
      end
   end

   a_r3_drain_holds: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DRAIN && halt_req && in_frame) |=> state == ST_DRAIN);
   a_r7_busoff_hold: assert property (@(posedge clk) disable iff (rst)
      (state == ST_BOFF && halt_req) |=> state == ST_BOFF);
   a_r10_cancel_no_halt: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DRAIN && !halt_req) |=> state == ST_ACTIVE);
endmodule

// File: rtl/can_halt_seq.sv
module can_halt_seq
   import can_halt_pkg::*;
#(
   parameter int RUN_LEN = 11
) (
   input  logic clk,
   input  logic rst,
   input  logic halt_req,
   input  logic eng_tx,
   input  logic eng_rx,
   input  logic eng_idle,
   input  logic eng_intermission,
   input  logic eng_bus_off,
   input  logic bit_tick,
   input  logic rx_bit,
   output logic bus_en,
   output logic halted,
   output logic halt_irq,
   output logic cfg_wr_ok
);
   halt_state_t state;
   logic        run_done;
   logic        run_clr;

   assign run_clr = (state != ST_REJOIN) | halt_req;

   can_halt_runcnt #(.RUN_LEN(RUN_LEN)) u_run (
      .clk    (clk),
      .rst    (rst),
      .clr    (run_clr),
      .tick   (bit_tick),
      .bit_in (rx_bit),
      .done   (run_done)
   );

   can_halt_fsm u_fsm (
      .clk              (clk),
      .rst              (rst),
      .halt_req         (halt_req),
      .eng_tx           (eng_tx),
      .eng_rx           (eng_rx),
      .eng_idle         (eng_idle),
      .eng_intermission (eng_intermission),
      .eng_bus_off      (eng_bus_off),
      .run_done         (run_done),
      .state            (state),
      .irq_q            (halt_irq),
      .flag_q           (halted)
   );

   assign bus_en    = (state == ST_ACTIVE) | (state == ST_DRAIN);
   assign cfg_wr_ok = (state == ST_HALTED);

   a_r4_irq_pulse: assert property (@(posedge clk) disable iff (rst)
      halt_irq |=> !halt_irq);
   a_r6_cfg_only_halted: assert property (@(posedge clk) disable iff (rst)
      cfg_wr_ok |-> (halted && !bus_en));
   a_r8_join_on_recessive: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_en) |-> $past(bit_tick && rx_bit));
   a_r5_flag_until_join: assert property (@(posedge clk) disable iff (rst)
      (halted && !bus_en) |=> (halted || bus_en));
endmodule

// File: tb/can_halt_seq_test.sv
module can_halt_seq_test;
   logic clk = 1'b0;
   logic rst, halt_req, eng_tx, eng_rx, eng_idle, eng_intermission, eng_bus_off;
   logic bit_tick, rx_bit;
   logic bus_en, halted, halt_irq, cfg_wr_ok;
   int   n_chk = 0;
   int   n_bad = 0;

   always #2.5 clk = ~clk;

   can_halt_seq #(.RUN_LEN(11)) uut (
      .clk(clk), .rst(rst), .halt_req(halt_req), .eng_tx(eng_tx), .eng_rx(eng_rx),
      .eng_idle(eng_idle), .eng_intermission(eng_intermission),
      .eng_bus_off(eng_bus_off), .bit_tick(bit_tick), .rx_bit(rx_bit),
      .bus_en(bus_en), .halted(halted), .halt_irq(halt_irq), .cfg_wr_ok(cfg_wr_ok)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic send_bits(input int n, input logic v);
      for (int i = 0; i < n; i++) begin
         bit_tick = 1'b1; rx_bit = v;
         @(negedge clk);
         bit_tick = 1'b0; rx_bit = 1'b1;
         @(negedge clk);
         @(negedge clk);
      end
   endtask

   task automatic idle_inputs();
      halt_req = 0; eng_tx = 0; eng_rx = 0; eng_idle = 1;
      eng_intermission = 0; eng_bus_off = 0; bit_tick = 0; rx_bit = 1;
   endtask

   task automatic t_reset();
      idle_inputs();
      rst = 1;
      @(negedge clk); @(negedge clk);
      rst = 0;
      @(negedge clk);
      chk("R1 bus_en", bus_en, 0);
      chk("R1 halted", halted, 0);
      chk("R1 irq", halt_irq, 0);
      chk("R1 cfg", cfg_wr_ok, 0);
      for (int i = 0; i < 30; i++) @(negedge clk);
      chk("R9 no tick no join", bus_en, 0);
      send_bits(10, 1);
      chk("R1 after 10 bits", bus_en, 0);
      send_bits(1, 1);
      chk("R1 after 11 bits", bus_en, 1);
   endtask

   task automatic rejoin_check(input string req);
      send_bits(5, 1);
      send_bits(1, 0);
      send_bits(10, 1);
      chk({req, " R8 dominant restart"}, bus_en, 0);
      chk({req, " R5 flag in rejoin"}, halted, 1);
      send_bits(1, 1);
      chk({req, " R8 joined"}, bus_en, 1);
      chk({req, " R5 flag cleared"}, halted, 0);
   endtask

   task automatic t_idle_halt();
      eng_idle = 1;
      halt_req = 1;
      @(negedge clk);
      chk("R2 halted idle", halted, 1);
      chk("R2 bus_en off", bus_en, 0);
      chk("R4 irq on entry", halt_irq, 1);
      chk("R6 cfg permit", cfg_wr_ok, 1);
      @(negedge clk);
      chk("R4 irq single", halt_irq, 0);
      chk("R5 flag level", halted, 1);
      halt_req = 0;
      @(negedge clk);
      chk("R6 cfg drops", cfg_wr_ok, 0);
      chk("R5 flag after clear", halted, 1);
      rejoin_check("idle");
   endtask

   task automatic t_intermission_halt();
      eng_idle = 0; eng_intermission = 1;
      halt_req = 1;
      @(negedge clk);
      chk("R2 halted intermission", halted, 1);
      chk("R4 irq intermission", halt_irq, 1);
      halt_req = 0; eng_intermission = 0; eng_idle = 1;
      @(negedge clk);
      send_bits(11, 1);
      chk("R8 rejoin after intermission", bus_en, 1);
   endtask

   task automatic t_frame_halt(input logic use_tx);
      eng_idle = 0; eng_tx = use_tx; eng_rx = ~use_tx;
      halt_req = 1;
      for (int i = 0; i < 5; i++) @(negedge clk);
      chk("R3 bus_en during frame", bus_en, 1);
      chk("R3 not halted during frame", halted, 0);
      eng_tx = 0; eng_rx = 0; eng_idle = 1;
      @(negedge clk);
      chk("R3 halted after frame", halted, 1);
      chk("R4 irq after frame", halt_irq, 1);
      halt_req = 0;
      @(negedge clk);
      send_bits(11, 1);
      chk("R8 rejoin after frame", bus_en, 1);
   endtask

   task automatic t_drain_cancel();
      logic seen = 1'b0;
      eng_idle = 0; eng_rx = 1; halt_req = 1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         seen |= halt_irq;
      end
      halt_req = 0;
      @(negedge clk);
      seen |= halt_irq;
      eng_rx = 0; eng_idle = 1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         seen |= halt_irq;
      end
      chk("R10 no irq", seen, 0);
      chk("R10 not halted", halted, 0);
      chk("R10 bus_en kept", bus_en, 1);
   endtask

   task automatic t_busoff();
      eng_idle = 0; eng_bus_off = 1; halt_req = 1;
      @(negedge clk);
      chk("R7 bus_en off", bus_en, 0);
      chk("R7 not halted", halted, 0);
      chk("R7 no cfg", cfg_wr_ok, 0);
      eng_bus_off = 0; eng_idle = 1;
      send_bits(128 * 11 + 11, 1);
      chk("R7 still off after recovery", bus_en, 0);
      chk("R7 still not halted", halted, 0);
      halt_req = 0;
      @(negedge clk);
      send_bits(10, 1);
      chk("R7 needs full run", bus_en, 0);
      send_bits(1, 1);
      chk("R7 released", bus_en, 1);
   endtask

   initial begin
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_idle_halt();
      t_intermission_halt();
      t_frame_halt(1'b1);
      t_frame_halt(1'b0);
      t_drain_cancel();
      t_busoff();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule